// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This core keeps wall-clock time as a 32-bit count of seconds and raises two interrupts: one for every elapsed second and one when the count reaches a programmed alarm value. A separate prescaler delivers a one-cycle pulse on `tick_i` once per second. The prescaler also reports its sub-second count to this core and takes a calibration word from it. Software reaches the core over a simple word-addressed register bus. Writes take effect on the clock edge where `wr_i` is high. Reads are combinational from `addr_i`.

Setting the time is deferred. A value written to the set-time register is held in a staging register and is copied into the running counter only on the next second tick. Until that tick, the staged value can be read back and the current-time register still shows the old count. Software clears the seconds status bit right after writing a new time. It can then tell from that bit whether the copy has happened. Interrupt sources are masked at reset. Separate enable and disable registers unmask or mask a source without a read-modify-write.

Top module: `rtc_sec_core`

Register byte offsets (bits [1:0] of `addr_i` are ignored):

| Offset | Access | Function |
|---|---|---|
| 0x00 | W | set-time staging write |
| 0x04 | R | staged value |
| 0x08 | W | calibration write |
| 0x0C | R | calibration value |
| 0x10 | R | current time |
| 0x14 | R | prescaler tick count |
| 0x18 | R/W | alarm |
| 0x20 | R/W1C | status |
| 0x24 | R | mask |
| 0x28 | W | unmask |
| 0x2C | W | mask |
| 0x40 | R/W | control |

## Requirements
- R1: After reset the following hold:
  - current time (0x10) reads 0 and status (0x20) reads 0;
  - mask (0x24) reads 3, meaning both sources are masked;
  - control (0x40) reads 0;
  - calibration (0x0C) reads the CAL_RST parameter;
  - both interrupt outputs are low.
- R2: A write to 0x00 is readable at 0x04 on the next cycle, and current time (0x10) does not change until a tick arrives.
- R3: On a tick with a staged value pending, current time loads that value and the pending flag clears, so the following tick increments.
- R4: On a tick with nothing pending, current time increments by one, and 0xFFFFFFFF wraps to 0.
- R5: Status bit 1 (alarm) is set on the tick whose new current time equals the alarm register (0x18). This includes a time that arrives through a staged load.
- R6: Writing 0x20 clears each status bit written as 1 and leaves bits written as 0 unchanged. Every tick sets status bit 0. When a tick and a clearing write fall in the same cycle, the set wins.
- R7: Mask bit 0 covers the seconds source and mask bit 1 covers the alarm source. A write to 0x28 clears the mask bits written as 1, and a write to 0x2C sets them. Bits written as 0 keep their value.
- R8: `sec_irq_o` is status bit 0 AND NOT mask bit 0. `alarm_irq_o` is status bit 1 AND NOT mask bit 1.
- R9: Control (0x40) stores only bits 31 and 24, and all other bits read as 0.
- R10: A write to 0x08 stores the low 21 bits, which read back at 0x0C and drive `cal_o`. Offset 0x14 returns `tick_cnt_i`.
- R11: A set-time write in the same cycle as a tick does not affect that tick: the tick loads the previously pending value, or increments if none is pending. The new value is loaded on the following tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| tick_i | input | 1 | one-cycle pulse per elapsed second |
| wr_i | input | 1 | register write strobe |
| addr_i | input | 7 | byte offset of the register |
| wdata_i | input | 32 | write data |
| rdata_o | output | 32 | read data for `addr_i` |
| tick_cnt_i | input | 16 | sub-second count from the prescaler |
| cal_o | output | 21 | calibration word to the prescaler |
| sec_irq_o | output | 1 | seconds interrupt |
| alarm_irq_o | output | 1 | alarm interrupt |

## Verification
Two pairs of functions can collide in one cycle.
- The first pair is a second tick, which sets status bit 0, and a software write-one-to-clear of that bit. The bench drives both in the same cycle and expects the bit to read 1 afterwards.
- The second pair is a set-time write landing on a tick. The bench expects that tick to use the older state, with the new value appearing only one tick later. This is checked both with and without a value already pending.

// File: rtl/rtc_sec_core.sv
module rtc_sec_core #(
  parameter int DW = 32,
  parameter int AW = 7,
  parameter int CAL_W = 21,
  parameter int TICK_W = 16,
  parameter logic [CAL_W-1:0] CAL_RST = 21'h198233
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [TICK_W-1:0] tick_cnt_i,
  output logic [CAL_W-1:0]  cal_o,
  output logic              sec_irq_o,
  output logic              alarm_irq_o
);
  localparam int WW = AW - 2;
  localparam logic [WW-1:0] W_SET   = WW'(0);
  localparam logic [WW-1:0] W_STG   = WW'(1);
  localparam logic [WW-1:0] W_CALW  = WW'(2);
  localparam logic [WW-1:0] W_CALR  = WW'(3);
  localparam logic [WW-1:0] W_CUR   = WW'(4);
  localparam logic [WW-1:0] W_TCNT  = WW'(5);
  localparam logic [WW-1:0] W_ALM   = WW'(6);
  localparam logic [WW-1:0] W_STS   = WW'(8);
  localparam logic [WW-1:0] W_MSK   = WW'(9);
  localparam logic [WW-1:0] W_EN    = WW'(10);
  localparam logic [WW-1:0] W_DIS   = WW'(11);
  localparam logic [WW-1:0] W_CTL   = WW'(16);
  localparam int BATT_BIT = 31;
  localparam int OSC_BIT  = 24;

  logic [DW-1:0]    cur_q, stage_q, alarm_q, next_cur;
  logic             pend_q;
  logic [1:0]       sts_q, mask_q, sts_clr, sts_set;
  logic [1:0]       ctl_q;
  logic [CAL_W-1:0] cal_q;
  logic [WW-1:0]    widx;

  assign widx     = addr_i[AW-1:2];
  assign next_cur = pend_q ? stage_q : cur_q + 1'b1;
  assign sts_clr  = (wr_i && widx == W_STS) ? wdata_i[1:0] : 2'b00;
  assign sts_set  = {tick_i && (next_cur == alarm_q), tick_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q   <= '0;
      stage_q <= '0;
      pend_q  <= 1'b0;
      alarm_q <= '0;
      sts_q   <= 2'b00;
      mask_q  <= 2'b11;
      ctl_q   <= 2'b00;
      cal_q   <= CAL_RST;
    end else begin
      if (tick_i) cur_q <= next_cur;
      if (wr_i && widx == W_SET) begin
        stage_q <= wdata_i;
        pend_q  <= 1'b1;
      end else if (tick_i) begin
        pend_q  <= 1'b0;
      end
      sts_q <= (sts_q & ~sts_clr) | sts_set;
      if (wr_i) begin
        case (widx)
          W_ALM:   alarm_q <= wdata_i;
          W_EN:    mask_q  <= mask_q & ~wdata_i[1:0];
          W_DIS:   mask_q  <= mask_q | wdata_i[1:0];
          W_CTL:   ctl_q   <= {wdata_i[BATT_BIT], wdata_i[OSC_BIT]};
          W_CALW:  cal_q   <= wdata_i[CAL_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (widx)
      W_STG:  rdata_o = stage_q;
      W_CALR: rdata_o = DW'(cal_q);
      W_CUR:  rdata_o = cur_q;
      W_TCNT: rdata_o = DW'(tick_cnt_i);
      W_ALM:  rdata_o = alarm_q;
      W_STS:  rdata_o = DW'(sts_q);
      W_MSK:  rdata_o = DW'(mask_q);
      W_CTL: begin
        rdata_o[BATT_BIT] = ctl_q[1];
        rdata_o[OSC_BIT]  = ctl_q[0];
      end
      default: rdata_o = '0;
    endcase
  end

  assign cal_o       = cal_q;
  assign sec_irq_o   = sts_q[0] & ~mask_q[0];
  assign alarm_irq_o = sts_q[1] & ~mask_q[1];
endmodule

// File: rtl/rtc_sec_core_chk.sv
module rtc_sec_core_chk #(
  parameter int DW = 32,
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_i,
  input logic          wr_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] cur,
  input logic [DW-1:0] stage,
  input logic          pend,
  input logic [DW-1:0] alarm,
  input logic [1:0]    sts,
  input logic [1:0]    mask
);
  logic en_wr, dis_wr;
  assign en_wr  = wr_i && addr_i[AW-1:2] == (AW-2)'(10);
  assign dis_wr = wr_i && addr_i[AW-1:2] == (AW-2)'(11);

  // R2
  time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cur));
  // R3
  staged_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && pend |=> cur == $past(stage));
  // R4
  increment_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !pend |=> cur == $past(cur) + 1'b1);
  // R5
  alarm_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[1]) |-> $past(tick_i) && cur == $past(alarm));
  // R6
  sec_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> sts[0]);
  // R7
  unmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr && wdata_i[0] |=> !mask[0]);
  // R7
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_wr && wdata_i[1] |=> mask[1]);
endmodule

bind rtc_sec_core rtc_sec_core_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .cur(cur_q), .stage(stage_q), .pend(pend_q),
  .alarm(alarm_q), .sts(sts_q), .mask(mask_q)
);

// File: tb/rtc_sec_core_tb.sv
module rtc_sec_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [6:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] tick_cnt_i = 16'hABCD;
  logic [20:0] cal_o;
  logic        sec_irq_o, alarm_irq_o;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  rtc_sec_core dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .tick_cnt_i(tick_cnt_i),
    .cal_o(cal_o), .sec_irq_o(sec_irq_o), .alarm_irq_o(alarm_irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit w, input logic [6:0] a, input logic [31:0] d, input bit t);
    @(negedge clk);
    wr_i = w; addr_i = a; wdata_i = d; tick_i = t;
    @(negedge clk);
    wr_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] v);
    addr_i = a;
    #1;
    v = rdata_o;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic tk();
    cyc(1'b0, 7'h00, 32'h0, 1'b1);
  endtask

  initial begin
    logic [31:0] v, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(7'h10, v); chk("R1 cur", v, 0);
    rd(7'h20, v); chk("R1 sts", v, 0);
    rd(7'h24, v); chk("R1 mask", v, 3);
    rd(7'h40, v); chk("R1 ctl", v, 0);
    rd(7'h0C, v); chk("R1 cal", v, 32'h198233);
    chk("R1 irqs", {30'b0, sec_irq_o, alarm_irq_o}, 0);

    for (int i = 1; i <= 3; i++) begin
      tk(); rd(7'h10, v); chk("R4 inc", v, i);
    end

    wr(7'h00, 32'h1000);
    rd(7'h04, v); chk("R2 readback", v, 32'h1000);
    repeat (3) @(negedge clk);
    rd(7'h10, v); chk("R2 cur held", v, 3);
    wr(7'h20, 32'h3);
    tk(); rd(7'h10, v); chk("R3 load", v, 32'h1000);
    rd(7'h20, v); chk("R6 tick sets sec", v & 1, 1);
    tk(); rd(7'h10, v); chk("R3 pending cleared", v, 32'h1001);

    wr(7'h00, 32'hFFFF_FFFE);
    tk(); tk(); rd(7'h10, v); chk("R4 max", v, 32'hFFFF_FFFF);
    tk(); rd(7'h10, v); chk("R4 wrap", v, 0);

    wr(7'h18, 32'd5);
    rd(7'h18, v); chk("R5 alarm rb", v, 5);
    wr(7'h20, 32'h3);
    for (int i = 1; i <= 4; i++) begin
      tk(); rd(7'h20, v); chk("R5 no early alarm", v & 2, 0);
    end
    tk(); rd(7'h20, v); chk("R5 alarm on match", v & 2, 2);
    wr(7'h18, 32'h500); wr(7'h00, 32'h500); wr(7'h20, 32'h3);
    tk(); rd(7'h20, v); chk("R5 alarm via load", v & 2, 2);

    for (int w = 0; w < 4; w++) begin
      rd(7'h10, c);
      wr(7'h18, c + 1);
      tk(); rd(7'h20, v); chk("R6 both set", v, 3);
      wr(7'h20, w); rd(7'h20, v); chk("R6 w1c", v, 3 & ~w);
    end
    wr(7'h20, 32'h3);
    cyc(1'b1, 7'h20, 32'h1, 1'b1);
    rd(7'h20, v); chk("R6 set wins", v & 1, 1);

    for (int m = 0; m < 4; m++) begin
      for (int w = 0; w < 4; w++) begin
        wr(7'h2C, 3); wr(7'h28, 3 & ~m);
        wr(7'h28, w); rd(7'h24, v); chk("R7 enable", v, m & ~w & 3);
        wr(7'h2C, 3); wr(7'h28, 3 & ~m);
        wr(7'h2C, w); rd(7'h24, v); chk("R7 disable", v, (m | w) & 3);
      end
    end

    wr(7'h28, 3);
    rd(7'h10, c); wr(7'h18, c + 1); tk();
    chk("R8 both irq", {30'b0, sec_irq_o, alarm_irq_o}, 3);
    wr(7'h20, 1);
    chk("R8 sec cleared", {30'b0, sec_irq_o, alarm_irq_o}, 1);
    wr(7'h2C, 2);
    chk("R8 alarm masked", {30'b0, sec_irq_o, alarm_irq_o}, 0);

    wr(7'h40, 32'hFFFF_FFFF); rd(7'h40, v); chk("R9 ctl ones", v, 32'h8100_0000);
    wr(7'h40, 32'h0100_0000); rd(7'h40, v); chk("R9 ctl osc", v, 32'h0100_0000);
    wr(7'h08, 32'hFFFF_FFFF); rd(7'h0C, v); chk("R10 cal rb", v, 32'h1F_FFFF);
    chk("R10 cal out", {11'b0, cal_o}, 32'h1F_FFFF);
    rd(7'h14, v); chk("R10 tick cnt", v, 32'hABCD);

    rd(7'h10, c);
    cyc(1'b1, 7'h00, 32'h7777, 1'b1);
    rd(7'h10, v); chk("R11 tick ignores new write", v, c + 1);
    tk(); rd(7'h10, v); chk("R11 loaded next tick", v, 32'h7777);
    wr(7'h00, 32'hAAAA);
    cyc(1'b1, 7'h00, 32'hBBBB, 1'b1);
    rd(7'h10, v); chk("R11 older pending used", v, 32'hAAAA);
    tk(); rd(7'h10, v); chk("R11 newer follows", v, 32'hBBBB);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule